// File: doc/BRIEF.md
# Register-Read Packet Receive Queue

This block takes 32-bit words from a stream input that marks the final word of each packet, keeps the words in a small storage array, and records each packet's length in a separate length queue. A processor drains it through a simple register port. It first reads the occupancy register to see whether complete packets are waiting. It then reads the length register, which releases the next packet's byte count. Finally it reads the data register once per word of that packet.

Reads that break this sequence raise sticky flags in a shared interrupt status register, and each flag can be enabled onto a single interrupt line. The flags cover a data read with nothing stored, a data read past the end of the current packet, and a length read that abandons an undrained packet. Writing the key value 0xA5 to one of two reset registers clears the receive path; the block-wide reset also clears the interrupt registers. The stream input applies back-pressure instead of dropping words. A packet must fit entirely in the word storage.

Top module: `pkt_rx_regfifo`

## Requirements
- R1: `s_tready` is low while the word storage holds DEPTH words or the length queue holds LEN_DEPTH entries, so no offered word is lost; it is high otherwise, including after reset.
- R2: Accepting a word with `s_tlast` high queues that packet's length and sets status bit 26 (receive complete) one cycle later.
- R3: Reading offset 0x1C returns the number of stored words belonging to complete packets not yet read or discarded; it is nonzero whenever a complete packet waits, and it is 0 after reset.
- R4: Reading offset 0x24 removes the oldest queued length and returns it in bytes (4 times the word count). With no length queued, it returns 0 and changes no state.
- R5: Reading offset 0x20 after a length read returns that packet's words in arrival order, one word per read, for byte length/4 reads.
- R6: A read of 0x20 when the current packet is used up and the occupancy is 0 returns 0 and sets status bit 29 (empty read).
- R7: A read of 0x20 when the current packet is used up but the occupancy is nonzero returns 0, sets status bit 30 (over-read), and consumes no word.
- R8: A read of 0x24 while words of the previous packet remain unread sets status bit 31 (under-read) and discards those words, so that the next data read returns the new packet's first word.
- R9: Status (0x00) keeps only bits 31, 30, 29, 26 and 23. Writing 1 to a bit clears it, and writing to any other bit has no effect. Enable (0x04) holds only bits within mask 0xFFF80000. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Writing 0xA5 to 0x18 empties the word storage and the length queue, keeps the enable register, and sets status bit 23 (reset complete). Any other value written there changes nothing.
- R11: Writing 0xA5 to 0x28 does what R10 does, clears the enable register, and clears every status bit except bit 23, which it sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Stream word |
| s_tvalid | input | 1 | Stream word offered |
| s_tlast | input | 1 | Offered word ends its packet |
| s_tready | output | 1 | Block can take the offered word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; side effects occur at the clock edge |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| irq | output | 1 | Any enabled status bit set |

## Verification
The bench sweeps every packet length from one word up to the full storage depth. For each length it compares occupancy, byte length and every word against values it computes from the length and a per-packet base. Because each word's value encodes its packet and position, the sweep tells apart lost words, reordered words and off-by-one length counting. Separate orderings exercise the three misuse cases and show their different outcomes: several packets queued and drained, reads past a packet's end, and a length read that abandons a partly read packet. Filling the storage and then filling the length queue separates the two back-pressure causes. Keyed writes with the right and wrong values separate the two reset scopes.

// File: rtl/prf_pkg.sv
package prf_pkg;
    localparam logic [5:0] A_STATUS = 6'h00;
    localparam logic [5:0] A_ENABLE = 6'h04;
    localparam logic [5:0] A_RXRST  = 6'h18;
    localparam logic [5:0] A_OCC    = 6'h1C;
    localparam logic [5:0] A_DATA   = 6'h20;
    localparam logic [5:0] A_LEN    = 6'h24;
    localparam logic [5:0] A_ALLRST = 6'h28;

    localparam logic [31:0] RESET_KEY   = 32'h0000_00A5;
    localparam logic [31:0] STATUS_IMPL = 32'hE480_0000;
    localparam logic [31:0] ENABLE_IMPL = 32'hFFF8_0000;

    localparam int B_UNDER = 31;
    localparam int B_OVER  = 30;
    localparam int B_EMPTY = 29;
    localparam int B_DONE  = 26;
    localparam int B_RST   = 23;
endpackage

// File: rtl/prf_word_store.sv
module prf_word_store #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [31:0]   din,
    input  logic [AW:0]   rel_n,
    output logic [31:0]   dout,
    output logic [AW:0]   count,
    output logic          full
);
    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
        logic [AW:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [31:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.wr  = st_q.wr + {{AW{1'b0}}, push};
            st_d.rd  = st_q.rd + rel_n;
            st_d.cnt = st_q.cnt + {{AW{1'b0}}, push} - rel_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wr[AW-1:0]] <= din;
    end

    assign dout  = mem[st_q.rd[AW-1:0]];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == (AW+1)'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full) else $error("word pushed into full storage"); // R1
    AST_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (rel_n <= st_q.cnt)) else $error("released more words than stored"); // R8
endmodule

// File: rtl/prf_len_queue.sv
module prf_len_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    localparam int QW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    typedef struct packed {
        logic [QW:0] wr;
        logic [QW:0] rd;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.wr = st_q.wr + {{QW{1'b0}}, push};
            st_d.rd = st_q.rd + {{QW{1'b0}}, pop};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wr[QW-1:0]] <= din;
    end

    assign dout  = mem[st_q.rd[QW-1:0]];
    assign empty = (st_q.wr == st_q.rd);
    assign full  = (st_q.wr[QW-1:0] == st_q.rd[QW-1:0]) && (st_q.wr[QW] != st_q.rd[QW]);

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (din != '0)) else $error("zero-length packet queued"); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("length popped from empty queue"); // R4
endmodule

// File: rtl/prf_irq_regs.sv
module prf_irq_regs
    import prf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_all,
    input  logic [31:0] set_bits,
    input  logic        w1c_en,
    input  logic        en_wr,
    input  logic [31:0] wdata,
    output logic [31:0] status,
    output logic [31:0] enable,
    output logic        irq
);
    typedef struct packed {
        logic [31:0] status;
        logic [31:0] enable;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.status = '0;
            st_d.enable = '0;
        end else begin
            if (w1c_en) st_d.status = st_q.status & ~wdata;
            if (en_wr)  st_d.enable = wdata & ENABLE_IMPL;
        end
        st_d.status = (st_d.status | set_bits) & STATUS_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign enable = st_q.enable;
    assign irq    = |(st_q.status & st_q.enable);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_UNDER] && !w1c_en && !clr_all) |=> status[B_UNDER]) else $error("flag lost without clear"); // R9
    AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_bits[B_RST] |=> status[B_RST]) else $error("reset-complete flag not set"); // R10
endmodule

// File: rtl/pkt_rx_regfifo.sv
module pkt_rx_regfifo
    import prf_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LEN_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] remain;
        logic [AW:0] committed;
        logic [AW:0] pkt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          store_full, lq_empty, lq_full;
    logic [AW:0]   store_cnt, lq_dout, rel_n;
    logic [31:0]   store_dout, status, enable, set_bits;
    logic          key_ok, rx_hit, all_hit, any_hit;
    logic          accept, end_pkt, rd_len, rd_data;
    logic          len_pop, under_read, data_ok, empty_rd, over_rd;

    assign key_ok  = reg_wr_en && (reg_wdata == RESET_KEY);
    assign rx_hit  = key_ok && (reg_addr == A_RXRST);
    assign all_hit = key_ok && (reg_addr == A_ALLRST);
    assign any_hit = rx_hit || all_hit;

    assign s_tready = !store_full && !lq_full && !any_hit;
    assign accept   = s_tvalid && s_tready;
    assign end_pkt  = accept && s_tlast;

    assign rd_len     = reg_rd_en && (reg_addr == A_LEN);
    assign rd_data    = reg_rd_en && (reg_addr == A_DATA);
    assign len_pop    = rd_len && !lq_empty && !any_hit;
    assign under_read = len_pop && (ctl_q.remain != '0);
    assign data_ok    = rd_data && (ctl_q.remain != '0) && !any_hit;
    assign empty_rd   = rd_data && (ctl_q.remain == '0) && (ctl_q.committed == '0);
    assign over_rd    = rd_data && (ctl_q.remain == '0) && (ctl_q.committed != '0);

    always_comb begin
        rel_n = '0;
        if (data_ok)         rel_n = (AW+1)'(1);
        else if (under_read) rel_n = ctl_q.remain;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (any_hit) begin
            ctl_d = '0;
        end else begin
            if (accept) ctl_d.pkt = s_tlast ? '0 : ctl_q.pkt + (AW+1)'(1);
            ctl_d.committed = ctl_q.committed - rel_n
                            + (end_pkt ? ctl_q.pkt + (AW+1)'(1) : '0);
            if (len_pop)      ctl_d.remain = lq_dout;
            else if (data_ok) ctl_d.remain = ctl_q.remain - (AW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        set_bits          = '0;
        set_bits[B_UNDER] = under_read;
        set_bits[B_OVER]  = over_rd && !any_hit;
        set_bits[B_EMPTY] = empty_rd && !any_hit;
        set_bits[B_DONE]  = end_pkt;
        set_bits[B_RST]   = any_hit;
    end

    prf_word_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (any_hit),
        .push  (accept),
        .din   (s_tdata),
        .rel_n (rel_n),
        .dout  (store_dout),
        .count (store_cnt),
        .full  (store_full)
    );

    prf_len_queue #(.DEPTH(LEN_DEPTH), .W(AW+1)) u_lenq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (any_hit),
        .push  (end_pkt),
        .din   (ctl_q.pkt + (AW+1)'(1)),
        .pop   (len_pop),
        .dout  (lq_dout),
        .empty (lq_empty),
        .full  (lq_full)
    );

    prf_irq_regs u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (all_hit),
        .set_bits (set_bits),
        .w1c_en   (reg_wr_en && (reg_addr == A_STATUS)),
        .en_wr    (reg_wr_en && (reg_addr == A_ENABLE)),
        .wdata    (reg_wdata),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = status;
            A_ENABLE: reg_rdata = enable;
            A_OCC:    reg_rdata = 32'(ctl_q.committed);
            A_LEN:    reg_rdata = lq_empty ? 32'd0 : 32'(lq_dout) << 2;
            A_DATA:   reg_rdata = (ctl_q.remain != '0) ? store_dout : 32'd0;
            default:  reg_rdata = 32'd0;
        endcase
    end

    AST_TREADY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (store_cnt == (AW+1)'(DEPTH)) |-> !s_tready) else $error("ready while storage full"); // R1
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        end_pkt |=> status[B_DONE]) else $error("receive complete not flagged"); // R2
    AST_OCC_WHEN_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        !lq_empty |-> (ctl_q.committed != '0)) else $error("length queued with zero occupancy"); // R3
    AST_REMAIN_WITHIN_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.remain <= ctl_q.committed) else $error("current packet exceeds occupancy"); // R5
    AST_OVER_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (over_rd && !accept && !any_hit) |=> $stable(store_cnt)) else $error("over-read consumed a word"); // R7
    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> (ctl_q.committed == '0) && (store_cnt == '0) && lq_empty) else $error("keyed reset left data"); // R10
endmodule

// File: tb/pkt_rx_regfifo_bench.sv
module pkt_rx_regfifo_bench;
    localparam int DEPTH = 8;
    localparam int LEN_DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    pkt_rx_regfifo #(.DEPTH(DEPTH), .LEN_DEPTH(LEN_DEPTH)) u_pkt_rx_regfifo (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd_en = 1'b0;
    endtask

    function automatic logic [31:0] word_of(input int base, input int i);
        return 32'(base * 256 + i * 3 + 1);
    endfunction

    task automatic send(input int len, input int base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1; s_tdata = word_of(base, i); s_tlast = (i == len - 1);
            #1;
            while (!s_tready) begin
                @(negedge clk); #1;
            end
            @(posedge clk); #1;
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic drain_pkt(input string tag, input int len, input int base);
        logic [31:0] x;
        rd(6'h24, x);
        chk({tag, " length bytes"}, x, 32'(len * 4));
        for (int i = 0; i < len; i++) begin
            rd(6'h20, x);
            chk({tag, " data word"}, x, word_of(base, i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state: R1 R3 R9
        chk("R1 tready after reset", {31'd0, s_tready}, 32'd1);
        rd(6'h1C, v); chk("R3 occupancy after reset", v, 32'd0);
        rd(6'h00, v); chk("R9 status after reset", v, 32'd0);
        chk("R9 irq after reset", {31'd0, irq}, 32'd0);

        // Sweep all lengths: R2 R3 R4 R5
        for (int len = 1; len <= DEPTH; len++) begin
            wr(6'h00, 32'hFFFF_FFFF);
            send(len, len);
            rd(6'h00, v); chk("R2 receive complete flag", v, 32'h0400_0000);
            rd(6'h1C, v); chk("R3 occupancy equals packet words", v, 32'(len));
            if (len == DEPTH) chk("R1 tready low with storage full", {31'd0, s_tready}, 32'd0);
            drain_pkt("R4 R5 sweep", len, len);
            rd(6'h1C, v); chk("R3 occupancy after drain", v, 32'd0);
        end
        wr(6'h00, 32'h0400_0000);
        rd(6'h00, v); chk("R9 write-one clears flag", v, 32'd0);

        // Several packets queued: R3 R5
        send(3, 20); send(2, 21);
        rd(6'h1C, v); chk("R3 occupancy two packets", v, 32'd5);
        drain_pkt("R5 first of two", 3, 20);
        rd(6'h1C, v); chk("R3 occupancy one left", v, 32'd2);
        drain_pkt("R5 second of two", 2, 21);

        // Empty reads: R4 R6
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h24, v); chk("R4 empty length read", v, 32'd0);
        rd(6'h00, v); chk("R4 empty length read no flag", v, 32'd0);
        rd(6'h20, v); chk("R6 empty data read value", v, 32'd0);
        rd(6'h00, v); chk("R6 empty read flag", v, 32'h2000_0000);

        // Over-read: R7
        wr(6'h00, 32'hFFFF_FFFF);
        send(2, 30); send(1, 31);
        drain_pkt("R7 setup", 2, 30);
        rd(6'h20, v); chk("R7 over-read value", v, 32'd0);
        rd(6'h00, v); chk("R7 over-read flag", v & 32'hE000_0000, 32'h4000_0000);
        rd(6'h1C, v); chk("R7 over-read keeps word", v, 32'd1);
        drain_pkt("R7 next packet intact", 1, 31);

        // Under-read: R8
        wr(6'h00, 32'hFFFF_FFFF);
        send(3, 40); send(2, 41);
        rd(6'h24, v); chk("R8 first length", v, 32'd12);
        rd(6'h20, v); chk("R8 first word", v, word_of(40, 0));
        rd(6'h24, v); chk("R8 second length", v, 32'd8);
        rd(6'h00, v); chk("R8 under-read flag", v & 32'hE000_0000, 32'h8000_0000);
        rd(6'h1C, v); chk("R8 leftover discarded", v, 32'd2);
        rd(6'h20, v); chk("R8 new packet first word", v, word_of(41, 0));
        rd(6'h20, v); chk("R8 new packet second word", v, word_of(41, 1));

        // Length queue back-pressure: R1
        for (int p = 0; p < LEN_DEPTH; p++) send(1, 50 + p);
        chk("R1 tready low with length queue full", {31'd0, s_tready}, 32'd0);
        rd(6'h1C, v); chk("R1 occupancy with queue full", v, 32'(LEN_DEPTH));
        for (int p = 0; p < LEN_DEPTH; p++) drain_pkt("R1 queued packets", 1, 50 + p);
        chk("R1 tready back after drain", {31'd0, s_tready}, 32'd1);

        // Registers and interrupt: R9
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, v); chk("R9 enable implemented bits", v, 32'hFFF8_0000);
        wr(6'h00, 32'h0007_FFFF);
        rd(6'h00, v); chk("R9 unimplemented status write", v, 32'd0);
        wr(6'h04, 32'h0400_0000);
        chk("R9 irq idle", {31'd0, irq}, 32'd0);
        send(1, 60);
        chk("R9 irq on enabled flag", {31'd0, irq}, 32'd1);
        wr(6'h00, 32'h0400_0000);
        chk("R9 irq after clear", {31'd0, irq}, 32'd0);

        // Receive reset: R10
        wr(6'h18, 32'h0000_005A);
        rd(6'h1C, v); chk("R10 wrong key ignored", v, 32'd1);
        rd(6'h00, v); chk("R10 wrong key no flag", v, 32'd0);
        wr(6'h18, 32'h0000_00A5);
        rd(6'h1C, v); chk("R10 occupancy cleared", v, 32'd0);
        rd(6'h24, v); chk("R10 length queue cleared", v, 32'd0);
        rd(6'h00, v); chk("R10 reset complete flag", v, 32'h0080_0000);
        rd(6'h04, v); chk("R10 enable kept", v, 32'h0400_0000);
        send(2, 70);
        drain_pkt("R10 path usable after reset", 2, 70);

        // Block reset: R11
        rd(6'h20, v);
        wr(6'h04, 32'hFFFF_FFFF);
        send(1, 80);
        wr(6'h28, 32'h0000_00A5);
        rd(6'h04, v); chk("R11 enable cleared", v, 32'd0);
        rd(6'h00, v); chk("R11 status only reset flag", v, 32'h0080_0000);
        rd(6'h1C, v); chk("R11 occupancy cleared", v, 32'd0);
        chk("R11 irq low", {31'd0, irq}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule